// File: doc/BRIEF.md
# Alarm Status and Interrupt Aggregator

This block collects alarm events from the detectors of an E1 framer into two byte-wide status levels and reduces them to one interrupt line. The primary level holds seven latched event bits. Its top bit is a live summary of the secondary level, so the two levels form a chain. The secondary level holds seven latched event bits. Its top bit latches a summary input from a third level further down the chain. Each level has its own mask register. A mask bit set to 1 keeps the matching status bit from raising the interrupt. The status bit is still recorded.

Software reaches the block through a plain synchronous register port: an address, a read strobe, a write strobe and write data. Read data is registered. Reading a status register clears the latched bits in it. One address acts as a software reset. Any read or write to it puts every register back to its default value.

Top module: `alarm_aggregator`

## Requirements
- R1: After a hardware reset, `irq` is 0, both mask registers read FFh, the primary status (address 0) reads 88h and the secondary status (address 2) reads 80h. Bit 3 of the primary status and bit 7 of the secondary status start latched.
- R2: A read or a write to address 7 (any data) returns every register to its R1 default in that clock cycle. `irq` is 0 from the next cycle. A read of address 7 returns 00h.
- R3: A one-cycle pulse on `priEvt[i]` sets primary status bit i. A pulse on `secEvt[i]` sets secondary status bit i. A pulse on `terAny` sets secondary status bit 7. Each bit stays set until its register is read.
- R4: Primary status bit 7 reads 1 exactly while any bit of the secondary status is 1. Reading the primary status does not clear it.
- R5: A status read returns the value held before the read and clears the latched bits. An event that arrives in the same cycle as the read is not returned and stays set for the next read.
- R6: The primary mask (address 1) and secondary mask (address 3) can be written and read back. Writes to the status addresses 0 and 2 have no effect.
- R7: `irq` is registered. It rises the second clock edge after an unmasked event pulse starts: one edge to latch the status and one edge for `irq`. It falls one edge after the status is cleared.
- R8: `irq` is 1 when a primary bit 0..6 is set with its mask bit 0. It is also 1 when primary mask bit 7 is 0 and some secondary bit is set with its own mask bit 0. Masked bits are still recorded in the status.
- R9: `regRdata` is updated on the clock edge that samples `regRd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register address |
| regRd | input | 1 | Read strobe, one cycle per access |
| regWr | input | 1 | Write strobe, one cycle per access |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Registered read data |
| priEvt | input | 7 | Primary alarm event pulses |
| secEvt | input | 7 | Secondary alarm event pulses |
| terAny | input | 1 | Summary pulse from the third level |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench fires an event in the same cycle that the status register is read. A design that clears without merging new events would lose that event, and one that returns it early would show it in the current read. The bench reads the primary register twice while the secondary level is non-zero. A design that latches the extension bit instead of deriving it would clear it, or would keep it after the secondary register is emptied. The bench reaches the reset address with both a read and a write while an interrupt is pending. A decode that only reacts to writes, or an interrupt register left out of the reset, would leave the masks or `irq` wrong. The bench also tests masked secondary bits and the one-cycle interrupt latency. These catch mask polarity errors and a combinational or doubly delayed `irq`.

// File: rtl/alarm_agg_pkg.sv
package alarm_agg_pkg;
  localparam int DW  = 8;
  localparam int EVW = DW - 1;

  localparam logic [DW-1:0] PRI_DEFAULT  = 8'h88;
  localparam logic [DW-1:0] SEC_DEFAULT  = 8'h80;
  localparam logic [DW-1:0] MASK_DEFAULT = 8'hFF;

  localparam int ADR_PRI_STAT = 0;
  localparam int ADR_PRI_MASK = 1;
  localparam int ADR_SEC_STAT = 2;
  localparam int ADR_SEC_MASK = 3;
  localparam int ADR_SW_RESET = 7;

  typedef struct packed {
    logic rdPri;
    logic rdSec;
    logic rdPm;
    logic rdSm;
    logic wrPm;
    logic wrSm;
    logic swRst;
  } regStrobe_t;
endpackage

// File: rtl/alarm_latch_bank.sv
module alarm_latch_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swRst,
  input  logic         clr,
  input  logic [W-1:0] evt,
  output logic [W-1:0] stat
);
  logic [W-1:0] statQ;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       statQ[i] <= RST_VAL[i];
      else if (swRst)  statQ[i] <= RST_VAL[i];
      else             statQ[i] <= (statQ[i] & ~clr) | evt[i];
    end
  end

  assign stat = statQ;

  AST_EVENT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!swRst && (|evt)) |=> ((stat & $past(evt)) == $past(evt))); // R3

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (clr && !swRst && (evt == '0)) |=> (stat == '0)); // R5
endmodule

// File: rtl/alarm_reg_ctrl.sv
module alarm_reg_ctrl
  import alarm_agg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_PRI = ADDR_W'(ADR_PRI_STAT);
  localparam logic [ADDR_W-1:0] A_PM  = ADDR_W'(ADR_PRI_MASK);
  localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(ADR_SEC_STAT);
  localparam logic [ADDR_W-1:0] A_SM  = ADDR_W'(ADR_SEC_MASK);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(ADR_SW_RESET);

  logic readOnly;
  logic anyAccess;

  // a simultaneous read and write counts as a write
  assign readOnly  = regRd & ~regWr;
  assign anyAccess = regRd | regWr;

  always_comb begin
    strb       = '0;
    strb.swRst = anyAccess && (regAddr == A_RST);
    strb.rdPri = readOnly  && (regAddr == A_PRI);
    strb.rdSec = readOnly  && (regAddr == A_SEC);
    strb.rdPm  = readOnly  && (regAddr == A_PM);
    strb.rdSm  = readOnly  && (regAddr == A_SM);
    strb.wrPm  = regWr     && (regAddr == A_PM);
    strb.wrSm  = regWr     && (regAddr == A_SM);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdPri, strb.rdSec, strb.rdPm, strb.rdSm,
              strb.wrPm, strb.wrSm, strb.swRst})); // R6
endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_agg_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  regStrobe_t     strb,
  input  logic [DW-1:0]  regWdata,
  input  logic [EVW-1:0] priEvt,
  input  logic [EVW-1:0] secEvt,
  input  logic           terAny,
  output logic [DW-1:0]  regRdata,
  output logic           irq
);
  logic [EVW-1:0] priLat;
  logic [DW-1:0]  secLat;
  logic [DW-1:0]  priView;
  logic [DW-1:0]  priMask;
  logic [DW-1:0]  secMask;
  logic           extBit;
  logic           irqNext;
  logic           irqQ;
  logic [DW-1:0]  rdataQ;

  alarm_latch_bank #(.W(EVW), .RST_VAL(PRI_DEFAULT[EVW-1:0])) u_priBank (
    .clk(clk), .rstN(rstN), .swRst(strb.swRst), .clr(strb.rdPri),
    .evt(priEvt), .stat(priLat)
  );

  alarm_latch_bank #(.W(DW), .RST_VAL(SEC_DEFAULT)) u_secBank (
    .clk(clk), .rstN(rstN), .swRst(strb.swRst), .clr(strb.rdSec),
    .evt({terAny, secEvt}), .stat(secLat)
  );

  // extension bit is a live summary of the secondary level
  assign extBit  = |secLat;
  assign priView = {extBit, priLat};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priMask <= MASK_DEFAULT;
      secMask <= MASK_DEFAULT;
    end else if (strb.swRst) begin
      priMask <= MASK_DEFAULT;
      secMask <= MASK_DEFAULT;
    end else begin
      if (strb.wrPm) priMask <= regWdata;
      if (strb.wrSm) secMask <= regWdata;
    end
  end

  always_comb begin
    irqNext = |(priLat & ~priMask[EVW-1:0]);
    if (!priMask[DW-1] && (|(secLat & ~secMask))) irqNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            irqQ <= 1'b0;
    else if (strb.swRst)  irqQ <= 1'b0;
    else                  irqQ <= irqNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdataQ <= '0;
    else if (strb.swRst)  rdataQ <= '0;
    else if (strb.rdPri)  rdataQ <= priView;
    else if (strb.rdSec)  rdataQ <= secLat;
    else if (strb.rdPm)   rdataQ <= priMask;
    else if (strb.rdSm)   rdataQ <= secMask;
  end

  assign irq      = irqQ;
  assign regRdata = rdataQ;

  AST_MASK_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    strb.swRst |=> (priMask == MASK_DEFAULT && secMask == MASK_DEFAULT)); // R2

  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (priMask == '1) |=> !irq); // R8

  AST_EXT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdPri && !strb.swRst && (|secLat) && !strb.rdSec) |=> priView[DW-1]); // R4
endmodule

// File: rtl/alarm_aggregator.sv
module alarm_aggregator
  import alarm_agg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic [EVW-1:0]    priEvt,
  input  logic [EVW-1:0]    secEvt,
  input  logic              terAny,
  output logic              irq
);
  regStrobe_t strb;

  alarm_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr),
    .regRd(regRd), .regWr(regWr), .strb(strb)
  );

  alarm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .priEvt(priEvt), .secEvt(secEvt), .terAny(terAny),
    .regRdata(regRdata), .irq(irq)
  );
endmodule

// File: tb/sim_alarm_aggregator.sv
`timescale 1ns/1ps
module sim_alarm_aggregator;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regRd = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [6:0] priEvt = '0;
  logic [6:0] secEvt = '0;
  logic       terAny = 1'b0;
  logic       irq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alarm_aggregator #(.ADDR_W(3)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .priEvt(priEvt), .secEvt(secEvt),
    .terAny(terAny), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    @(negedge clk); regRd = 1'b0; d = regRdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdCheck(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulsePri(input logic [6:0] b);
    @(negedge clk); priEvt = b;
    @(negedge clk); priEvt = '0;
  endtask

  task automatic pulseSec(input logic [6:0] b, input logic t);
    @(negedge clk); secEvt = b; terAny = t;
    @(negedge clk); secEvt = '0; terAny = 1'b0;
  endtask

  task automatic testReset();
    check("R1 irq", {7'b0, irq}, 8'h00);
    rdCheck(3'd1, 8'hFF, "R1 pmask");
    rdCheck(3'd3, 8'hFF, "R1 smask");
    rdCheck(3'd0, 8'h88, "R1 pri");
    rdCheck(3'd0, 8'h80, "R5 pri bit3 cleared");
    rdCheck(3'd2, 8'h80, "R1 sec");
    rdCheck(3'd0, 8'h00, "R4 ext follows sec");
  endtask

  task automatic testEvents();
    pulsePri(7'h04);
    @(negedge clk);
    check("R8 masked irq", {7'b0, irq}, 8'h00);
    rdCheck(3'd0, 8'h04, "R3 pri event");
    rdCheck(3'd0, 8'h00, "R5 cleared");
    pulseSec(7'h10, 1'b0);
    rdCheck(3'd0, 8'h80, "R4 ext set");
    rdCheck(3'd0, 8'h80, "R4 ext not cleared");
    rdCheck(3'd2, 8'h10, "R3 sec event");
    rdCheck(3'd0, 8'h00, "R4 ext gone");
  endtask

  task automatic testSameCycle();
    @(negedge clk); regAddr = 3'd0; regRd = 1'b1; priEvt = 7'h20;
    @(negedge clk); regRd = 1'b0; priEvt = '0;
    check("R5 same-cycle not returned", regRdata, 8'h00);
    rdCheck(3'd0, 8'h20, "R5 same-cycle kept");
  endtask

  task automatic testWrites();
    wr(3'd0, 8'hFF);
    wr(3'd2, 8'hFF);
    rdCheck(3'd0, 8'h00, "R6 pri write ignored");
    rdCheck(3'd2, 8'h00, "R6 sec write ignored");
    wr(3'd1, 8'h5A);
    rdCheck(3'd1, 8'h5A, "R6 pmask");
    wr(3'd3, 8'hA5);
    rdCheck(3'd3, 8'hA5, "R6 smask");
    @(negedge clk);
    check("R9 rdata held", regRdata, 8'hA5);
  endtask

  task automatic testIrq();
    wr(3'd1, 8'hFD);
    wr(3'd3, 8'hFF);
    pulsePri(7'h03);
    check("R7 irq not yet", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R7 irq rises", {7'b0, irq}, 8'h01);
    rdCheck(3'd0, 8'h03, "R8 masked bit recorded");
    @(negedge clk);
    check("R7 irq falls", {7'b0, irq}, 8'h00);
    pulsePri(7'h01);
    @(negedge clk);
    check("R8 masked bit no irq", {7'b0, irq}, 8'h00);
    rdCheck(3'd0, 8'h01, "R8 recorded");
  endtask

  task automatic testChain();
    wr(3'd1, 8'h7F);
    wr(3'd3, 8'hFE);
    pulseSec(7'h02, 1'b0);
    @(negedge clk);
    check("R8 sec masked", {7'b0, irq}, 8'h00);
    rdCheck(3'd0, 8'h80, "R4 ext from masked sec");
    pulseSec(7'h01, 1'b0);
    @(negedge clk);
    check("R8 sec unmasked irq", {7'b0, irq}, 8'h01);
    rdCheck(3'd2, 8'h03, "R3 sec bits");
    @(negedge clk);
    check("R7 chain irq falls", {7'b0, irq}, 8'h00);
    pulseSec(7'h00, 1'b1);
    @(negedge clk);
    check("R8 ter masked", {7'b0, irq}, 8'h00);
    rdCheck(3'd0, 8'h80, "R3 ter ext");
    rdCheck(3'd2, 8'h80, "R3 ter bit7");
  endtask

  task automatic testSwResetWrite();
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h00);
    pulsePri(7'h40);
    @(negedge clk);
    check("R2 irq pending", {7'b0, irq}, 8'h01);
    wr(3'd7, 8'h5A);
    check("R2 irq cleared", {7'b0, irq}, 8'h00);
    rdCheck(3'd1, 8'hFF, "R2 pmask");
    rdCheck(3'd3, 8'hFF, "R2 smask");
    rdCheck(3'd0, 8'h88, "R2 pri");
    rdCheck(3'd2, 8'h80, "R2 sec");
  endtask

  task automatic testSwResetRead();
    wr(3'd1, 8'h12);
    rdCheck(3'd1, 8'h12, "R6 pmask");
    rdCheck(3'd7, 8'h00, "R2 read returns 00");
    rdCheck(3'd1, 8'hFF, "R2 read resets pmask");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEvents();
    testSameCycle();
    testWrites();
    testIrq();
    testChain();
    testSwResetWrite();
    testSwResetRead();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule